// File: doc/BRIEF.md
# I2C Master Command Front End

This block is the part of an I2C master that software talks to. A word-addressed register port holds the slave address the master will target, the addressing-width select, the run enable and its shutdown status, DMA request controls with their watermarks, and a status word. Each write to the data/command register queues one 9-bit entry in a transmit command FIFO: a data byte with a direction bit beside it. Each read of the same register takes one received byte from a receive FIFO. Both FIFOs are 64 entries deep by default.

A small bus engine model stands in for the serial state machine. It takes entries in queue order, holds the master-active state for a fixed number of cycles per entry, reports each finished transfer on a set of observation outputs, and stores the byte present on `bus_rx_byte` whenever a read finishes. Reads and writes can be mixed freely in the queue. When software clears the enable, the transfer already under way completes, no new entry starts, and the enable-status bit falls only once the engine has gone idle. Both FIFOs are emptied at that point.

Top module: `i2cm_cmd_frontend`

Register word addresses: 0 control (bit 0 master mode, reset 1), 1 target, 2 data/command, 3 enable (bit 0), 4 enable status (bit 0), 5 status, 6 DMA control, 7 transmit watermark, 8 receive watermark, 9 transmit level, 10 receive level. Unlisted bits and addresses read as 0.

## Requirements
- R1: The target register keeps the slave address in bits 9:0 and the 10-bit addressing select in bit 12. All other bits read 0, and the register resets to 0.
- R2: A target write takes effect whenever the enable register (address 3, bit 0) is 0.
- R3: While the enable register is 1, a target write takes effect only if the engine is idle (status bit 5 = 0), control bit 0 is 1 and the transmit FIFO is empty (status bit 2 = 1). Otherwise it is ignored.
- R4: A data/command write queues {wdata[8], wdata[7:0]}. The engine runs the entries in queue order. Bit 8 = 0 is a write of the byte and bit 8 = 1 is a read. Each completion pulses `bus_xfer_done` for one cycle, with `bus_xfer_rd` and, for writes, `bus_xfer_byte` showing the entry.
- R5: The transmit FIFO holds 64 entries and its level reads at address 9. A data write while it is full is dropped and sets sticky status bit 3 (overflow). Writing status bit 3 as 1 clears it. Status bit 0 reads 1 when the transmit FIFO is full.
- R6: Every completed read stores the `bus_rx_byte` value seen at the completion edge in the receive FIFO (level at address 10). A read of address 2 returns the oldest byte in bits 7:0 and removes it.
- R7: Enable status bit 0 becomes 1 after enable is set. After enable goes from 1 to 0 it stays 1 until the transfer in progress completes, and no new entry is started.
- R8: When shutdown completes, both FIFOs are emptied.
- R9: Status bit 2 reads 1 exactly when the transmit FIFO is empty. Status bit 5 reads 1 while the engine is executing an entry.
- R10: `dma_tx_req` is 1 exactly when DMA control bit 0 is 1 and the transmit level is at or below the transmit watermark.
- R11: `dma_rx_req` is 1 exactly when DMA control bit 1 is 1 and the receive level is above the receive watermark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (removes a receive entry at address 2) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| bus_rx_byte | input | 8 | Byte the bus delivers when a read completes |
| bus_xfer_done | output | 1 | One-cycle pulse when an entry completes |
| bus_xfer_rd | output | 1 | Direction of the completing entry |
| bus_xfer_byte | output | 8 | Data byte of the completing entry |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The bench fills the transmit queue to exactly 64 while disabled and then pushes once more. A FIFO that miscounts at the wrap, or that accepts the extra entry, shows a wrong level or no overflow flag. It runs a 64-entry mix of reads and writes and compares every completion and every received byte in order, so a dropped direction bit, a reordered queue or a byte sampled in the wrong cycle appears as a mismatch. It sweeps both DMA watermarks across the full range at fixed levels, which catches an off-by-one between at-or-below and above. It tries target writes while busy, with master mode off, and finally with every condition met, then clears the enable in the middle of a read. A design that stops the transfer early, starts the next entry, drops the status bit too soon or keeps stale FIFO contents is caught there.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;

   localparam int REG_AW = 4;

   localparam logic [REG_AW-1:0] RA_CTRL   = 4'd0;
   localparam logic [REG_AW-1:0] RA_TARGET = 4'd1;
   localparam logic [REG_AW-1:0] RA_DATA   = 4'd2;
   localparam logic [REG_AW-1:0] RA_ENABLE = 4'd3;
   localparam logic [REG_AW-1:0] RA_ENSTAT = 4'd4;
   localparam logic [REG_AW-1:0] RA_STATUS = 4'd5;
   localparam logic [REG_AW-1:0] RA_DMACTL = 4'd6;
   localparam logic [REG_AW-1:0] RA_TXWM   = 4'd7;
   localparam logic [REG_AW-1:0] RA_RXWM   = 4'd8;
   localparam logic [REG_AW-1:0] RA_TXLVL  = 4'd9;
   localparam logic [REG_AW-1:0] RA_RXLVL  = 4'd10;

   // status word bit positions
   localparam int ST_TXFULL  = 0;
   localparam int ST_RXNE    = 1;
   localparam int ST_TXEMPTY = 2;
   localparam int ST_OVF     = 3;
   localparam int ST_RXFULL  = 4;
   localparam int ST_ACTIVE  = 5;

   // target word layout
   localparam int TAR_AW       = 10;
   localparam int TAR_MODE_BIT = 12;

   typedef struct packed {
      logic       rd;
      logic [7:0] data;
   } cmd_entry_t;

   localparam int CMD_W = $bits(cmd_entry_t);

endpackage

// File: rtl/i2cm_fifo.sv
`timescale 1ns/1ps
module i2cm_fifo #(
   parameter int W     = 9,
   parameter int DEPTH = 64,
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [LW-1:0] level,
   output logic          empty,
   output logic          full
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("i2cm_fifo: DEPTH must be a power of two of at least 2");
   end
   if (LW < $clog2(DEPTH + 1)) begin : g_bad_lw
      $error("i2cm_fifo: LW too narrow for DEPTH");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [LW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == LW'(DEPTH));
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign dout    = mem[rp];
   assign level   = cnt;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/i2cm_engine.sv
`timescale 1ns/1ps
module i2cm_engine
   import i2cm_pkg::*;
#(
   parameter int CMD_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       cmd_avail,
   input  cmd_entry_t cmd_in,
   input  logic [7:0] rx_byte,
   output logic       cmd_pop,
   output logic       busy,
   output logic       done,
   output logic       done_rd,
   output logic [7:0] done_byte,
   output logic       rx_push,
   output logic [7:0] rx_data
);
   localparam int CW = (CMD_CYCLES > 1) ? $clog2(CMD_CYCLES) : 1;

   if (CMD_CYCLES < 1) begin : g_bad_cycles
      $error("i2cm_engine: CMD_CYCLES must be at least 1");
   end

   cmd_entry_t    cur;
   logic [CW-1:0] cnt;

   assign cmd_pop   = run && cmd_avail && !busy;
   assign done      = busy && (cnt == '0);
   assign done_rd   = cur.rd;
   assign done_byte = cur.data;
   assign rx_push   = done && cur.rd;
   assign rx_data   = rx_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         cur  <= '0;
      end else if (cmd_pop) begin
         busy <= 1'b1;
         cnt  <= CW'(CMD_CYCLES - 1);
         cur  <= cmd_in;
      end else if (done) begin
         busy <= 1'b0;
      end else if (busy) begin
         cnt  <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/i2cm_dma_req.sv
`timescale 1ns/1ps
module i2cm_dma_req #(
   parameter int LW         = 7,
   parameter bit REGISTERED = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_en,
   input  logic          rx_en,
   input  logic [LW-1:0] tx_level,
   input  logic [LW-1:0] rx_level,
   input  logic [LW-1:0] tx_wm,
   input  logic [LW-1:0] rx_wm,
   output logic          tx_req,
   output logic          rx_req
);
   logic tx_raw, rx_raw;

   assign tx_raw = tx_en && (tx_level <= tx_wm);
   assign rx_raw = rx_en && (rx_level > rx_wm);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tx_req <= 1'b0;
            rx_req <= 1'b0;
         end else begin
            tx_req <= tx_raw;
            rx_req <= rx_raw;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign tx_req = tx_raw;
      assign rx_req = rx_raw;
   end
endmodule

// File: rtl/i2cm_cmd_frontend.sv
`timescale 1ns/1ps
module i2cm_cmd_frontend
   import i2cm_pkg::*;
#(
   parameter int FIFO_DEPTH  = 64,
   parameter int CMD_CYCLES  = 4,
   parameter bit DMA_REQ_REG = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [3:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic [7:0]  bus_rx_byte,
   output logic        bus_xfer_done,
   output logic        bus_xfer_rd,
   output logic [7:0]  bus_xfer_byte,
   output logic        dma_tx_req,
   output logic        dma_rx_req
);
   localparam int LW = $clog2(FIFO_DEPTH + 1);

   if (LW > 16) begin : g_bad_lw
      $error("i2cm_cmd_frontend: FIFO_DEPTH too large for the level fields");
   end

   // register state
   logic              master_mode;
   logic [TAR_AW-1:0] tar_addr;
   logic              tar_10b;
   logic              enable_q;
   logic              en_status;
   logic              ovf_flag;
   logic              tx_dma_en, rx_dma_en;
   logic [LW-1:0]     tx_wm, rx_wm;

   // datapath wires
   cmd_entry_t    tx_din, tx_dout;
   logic [LW-1:0] tx_level, rx_level;
   logic          tx_empty, tx_full, rx_empty, rx_full;
   logic          tx_pop, rx_push, rx_pop;
   logic [7:0]    rx_dout, rx_din;
   logic          eng_busy;
   logic          shutdown_done;
   logic          tar_ok;
   logic          data_wr, tar_wr;

   logic unused_wdata;
   assign unused_wdata = ^{reg_wdata[31:13], reg_wdata[11:10]};

   assign data_wr       = reg_wr && (reg_addr == RA_DATA);
   assign tar_wr        = reg_wr && (reg_addr == RA_TARGET);
   assign rx_pop        = reg_rd && (reg_addr == RA_DATA);
   assign tar_ok        = !enable_q || (!eng_busy && master_mode && tx_empty);
   assign shutdown_done = !enable_q && en_status && !eng_busy;
   assign tx_din        = '{rd: reg_wdata[8], data: reg_wdata[7:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_mode <= 1'b1;
         tar_addr    <= '0;
         tar_10b     <= 1'b0;
         enable_q    <= 1'b0;
         en_status   <= 1'b0;
         ovf_flag    <= 1'b0;
         tx_dma_en   <= 1'b0;
         rx_dma_en   <= 1'b0;
         tx_wm       <= '0;
         rx_wm       <= '0;
      end else begin
         if (reg_wr) begin
            case (reg_addr)
               RA_CTRL:   master_mode <= reg_wdata[0];
               RA_ENABLE: enable_q    <= reg_wdata[0];
               RA_DMACTL: begin
                  tx_dma_en <= reg_wdata[0];
                  rx_dma_en <= reg_wdata[1];
               end
               RA_TXWM:   tx_wm <= reg_wdata[LW-1:0];
               RA_RXWM:   rx_wm <= reg_wdata[LW-1:0];
               default: ;
            endcase
         end
         if (tar_wr && tar_ok) begin
            tar_addr <= reg_wdata[TAR_AW-1:0];
            tar_10b  <= reg_wdata[TAR_MODE_BIT];
         end
         if (enable_q)           en_status <= 1'b1;
         else if (shutdown_done) en_status <= 1'b0;
         if (data_wr && tx_full)
            ovf_flag <= 1'b1;
         else if (reg_wr && (reg_addr == RA_STATUS) && reg_wdata[ST_OVF])
            ovf_flag <= 1'b0;
      end
   end

   i2cm_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH), .LW(LW)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (shutdown_done),
      .push  (data_wr),
      .din   (tx_din),
      .pop   (tx_pop),
      .dout  (tx_dout),
      .level (tx_level),
      .empty (tx_empty),
      .full  (tx_full)
   );

   i2cm_fifo #(.W(8), .DEPTH(FIFO_DEPTH), .LW(LW)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (shutdown_done),
      .push  (rx_push),
      .din   (rx_din),
      .pop   (rx_pop),
      .dout  (rx_dout),
      .level (rx_level),
      .empty (rx_empty),
      .full  (rx_full)
   );

   i2cm_engine #(.CMD_CYCLES(CMD_CYCLES)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (enable_q),
      .cmd_avail (!tx_empty),
      .cmd_in    (tx_dout),
      .rx_byte   (bus_rx_byte),
      .cmd_pop   (tx_pop),
      .busy      (eng_busy),
      .done      (bus_xfer_done),
      .done_rd   (bus_xfer_rd),
      .done_byte (bus_xfer_byte),
      .rx_push   (rx_push),
      .rx_data   (rx_din)
   );

   i2cm_dma_req #(.LW(LW), .REGISTERED(DMA_REQ_REG)) u_dma (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_en    (tx_dma_en),
      .rx_en    (rx_dma_en),
      .tx_level (tx_level),
      .rx_level (rx_level),
      .tx_wm    (tx_wm),
      .rx_wm    (rx_wm),
      .tx_req   (dma_tx_req),
      .rx_req   (dma_rx_req)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL:   reg_rdata[0] = master_mode;
         RA_TARGET: begin
            reg_rdata[TAR_AW-1:0]   = tar_addr;
            reg_rdata[TAR_MODE_BIT] = tar_10b;
         end
         RA_DATA:   reg_rdata[7:0] = rx_dout;
         RA_ENABLE: reg_rdata[0] = enable_q;
         RA_ENSTAT: reg_rdata[0] = en_status;
         RA_STATUS: begin
            reg_rdata[ST_TXFULL]  = tx_full;
            reg_rdata[ST_RXNE]    = !rx_empty;
            reg_rdata[ST_TXEMPTY] = tx_empty;
            reg_rdata[ST_OVF]     = ovf_flag;
            reg_rdata[ST_RXFULL]  = rx_full;
            reg_rdata[ST_ACTIVE]  = eng_busy;
         end
         RA_DMACTL: reg_rdata[1:0] = {rx_dma_en, tx_dma_en};
         RA_TXWM:   reg_rdata[LW-1:0] = tx_wm;
         RA_RXWM:   reg_rdata[LW-1:0] = rx_wm;
         RA_TXLVL:  reg_rdata[LW-1:0] = tx_level;
         RA_RXLVL:  reg_rdata[LW-1:0] = rx_level;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/i2cm_cmd_frontend_chk.sv
`timescale 1ns/1ps
module i2cm_cmd_frontend_chk #(
   parameter int LW    = 7,
   parameter int DEPTH = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          enable_q,
   input logic          en_status,
   input logic          eng_busy,
   input logic [LW-1:0] tx_level,
   input logic [LW-1:0] rx_level,
   input logic          tx_empty,
   input logic          tx_full,
   input logic          master_mode,
   input logic [10:0]   tar_word,
   input logic          data_wr,
   input logic          ovf_flag,
   input logic          tx_dma_en,
   input logic          rx_dma_en,
   input logic          dma_tx_req,
   input logic          dma_rx_req
);
   // R7
   ensta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable_q && eng_busy) |-> en_status);

   // R7
   start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_busy) |-> $past(enable_q));

   // R8
   flush_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_status) |-> (tx_level == '0 && rx_level == '0));

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH));

   // R5
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && tx_full) |=> ovf_flag);

   // R3
   tar_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_q && (eng_busy || !master_mode || !tx_empty)) |=> $stable(tar_word));

   // R10
   dma_tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_tx_req |-> (tx_dma_en || $past(tx_dma_en)));

   // R11
   dma_rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_rx_req |-> (rx_dma_en || $past(rx_dma_en)));
endmodule

bind i2cm_cmd_frontend i2cm_cmd_frontend_chk #(.LW(LW), .DEPTH(FIFO_DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable_q    (enable_q),
   .en_status   (en_status),
   .eng_busy    (eng_busy),
   .tx_level    (tx_level),
   .rx_level    (rx_level),
   .tx_empty    (tx_empty),
   .tx_full     (tx_full),
   .master_mode (master_mode),
   .tar_word    ({tar_10b, tar_addr}),
   .data_wr     (data_wr),
   .ovf_flag    (ovf_flag),
   .tx_dma_en   (tx_dma_en),
   .rx_dma_en   (rx_dma_en),
   .dma_tx_req  (dma_tx_req),
   .dma_rx_req  (dma_rx_req)
);

// File: tb/i2cm_cmd_frontend_tb.sv
`timescale 1ns/1ps
module i2cm_cmd_frontend_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [3:0]  reg_addr = 4'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic [7:0]  bus_rx_byte = 8'd0;
   logic        bus_xfer_done, bus_xfer_rd;
   logic [7:0]  bus_xfer_byte;
   logic        dma_tx_req, dma_rx_req;

   int tests = 0;
   int fails = 0;

   // expected transfer list, filled as entries are accepted
   logic       exp_rd  [0:127];
   logic [7:0] exp_dat [0:127];
   int exp_n   = 0;
   int seen    = 0;
   int rx_seen = 0;

   always #10 clk = ~clk;

   i2cm_cmd_frontend #(.FIFO_DEPTH(64), .CMD_CYCLES(4), .DMA_REQ_REG(1'b0)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .reg_wr        (reg_wr),
      .reg_rd        (reg_rd),
      .reg_addr      (reg_addr),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .bus_rx_byte   (bus_rx_byte),
      .bus_xfer_done (bus_xfer_done),
      .bus_xfer_rd   (bus_xfer_rd),
      .bus_xfer_byte (bus_xfer_byte),
      .dma_tx_req    (dma_tx_req),
      .dma_rx_req    (dma_rx_req)
   );

   function automatic logic [7:0] rxval(input int j);
      return 8'h5A ^ 8'(j * 11);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      reg_rd   = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd   = 1'b0;
   endtask

   task automatic push_cmd(input logic rdc, input logic [7:0] b);
      wr(4'd2, {23'd0, rdc, b});
      exp_rd[exp_n]  = rdc;
      exp_dat[exp_n] = b;
      exp_n++;
   endtask

   // completion monitor: R4 order/direction, R6 byte source
   always @(negedge clk) begin
      bus_rx_byte = rxval(rx_seen);
      if (rst_n && bus_xfer_done) begin
         check("R4 direction", {31'd0, bus_xfer_rd}, {31'd0, exp_rd[seen]});
         if (!exp_rd[seen])
            check("R4 write byte", {24'd0, bus_xfer_byte}, {24'd0, exp_dat[seen]});
         if (bus_xfer_rd) rx_seen++;
         seen++;
      end
   end

   initial begin
      #4000000;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(4'd5, v);  check("R9 reset status", v, 32'h4);
      rd(4'd4, v);  check("R7 reset enstat", v, 32'h0);
      rd(4'd1, v);  check("R1 reset target", v, 32'h0);
      rd(4'd0, v);  check("R3 reset master mode", v, 32'h1);
      check("R10 reset tx req", {31'd0, dma_tx_req}, 32'd0);
      check("R11 reset rx req", {31'd0, dma_rx_req}, 32'd0);

      // R1/R2: field masking while disabled
      wr(4'd1, 32'hFFFF_FFFF);
      rd(4'd1, v);  check("R1 target mask", v, 32'h13FF);
      for (int k = 0; k < 16; k++) begin
         logic [31:0] w;
         w = (32'h0000_1111 * k) ^ (32'h5A5_0000 >> k);
         wr(4'd1, w);
         rd(4'd1, v);  check("R2 target write while disabled", v, w & 32'h13FF);
      end
      wr(4'd1, 32'h0000_1055);

      // R5: fill 64 mixed entries while disabled
      for (int i = 0; i < 64; i++) begin
         push_cmd((i % 3) == 1, 8'(i * 5 + 1));
         rd(4'd9, v);  check("R5 tx level", v, 32'(i + 1));
      end
      rd(4'd5, v);  check("R9 tx not empty / R5 full", v & 32'h5, 32'h1);
      // R10 watermark sweep at level 64
      wr(4'd6, 32'h1);
      for (int wm = 0; wm <= 64; wm++) begin
         wr(4'd7, 32'(wm));
         check("R10 tx req at level 64", {31'd0, dma_tx_req}, {31'd0, (64 <= wm)});
      end
      wr(4'd6, 32'h0);
      check("R10 tx req disabled", {31'd0, dma_tx_req}, 32'd0);
      // overflow
      wr(4'd2, 32'h0000_00EE);
      rd(4'd9, v);  check("R5 level after overflow", v, 32'd64);
      rd(4'd5, v);  check("R5 overflow flag", v & 32'h8, 32'h8);
      wr(4'd5, 32'h8);
      rd(4'd5, v);  check("R5 overflow clear", v & 32'h8, 32'h0);

      // run the queue
      wr(4'd3, 32'h1);
      repeat (2) @(negedge clk);
      rd(4'd5, v);  check("R9 active while running", v & 32'h20, 32'h20);
      rd(4'd4, v);  check("R7 enstat set", v, 32'h1);
      wr(4'd1, 32'h0000_0123);
      rd(4'd1, v);  check("R3 target write while busy ignored", v, 32'h1055);
      for (int n = 0; n < 2000; n++) begin
         rd(4'd5, v);
         if (seen == 64 && v[5] == 1'b0 && v[2] == 1'b1) break;
      end
      check("R4 all transfers done", 32'(seen), 32'd64);
      rd(4'd5, v);  check("R9 idle and empty", v & 32'h24, 32'h4);
      rd(4'd10, v); check("R6 rx level", v, 32'd21);

      // R11 watermark sweep at level 21
      wr(4'd6, 32'h2);
      for (int wm = 0; wm <= 64; wm++) begin
         wr(4'd8, 32'(wm));
         check("R11 rx req at level 21", {31'd0, dma_rx_req}, {31'd0, (21 > wm)});
      end
      // R10 at level 0
      wr(4'd6, 32'h1);
      for (int wm = 0; wm < 4; wm++) begin
         wr(4'd7, 32'(wm));
         check("R10 tx req at level 0", {31'd0, dma_tx_req}, 32'd1);
      end
      check("R11 rx req gated off", {31'd0, dma_rx_req}, 32'd0);
      wr(4'd6, 32'h0);

      // R3 guard while enabled
      wr(4'd0, 32'h0);
      wr(4'd1, 32'h0000_0200);
      rd(4'd1, v);  check("R3 target ignored without master mode", v, 32'h1055);
      wr(4'd0, 32'h1);
      wr(4'd1, 32'h0000_0200);
      rd(4'd1, v);  check("R3 target accepted when idle", v, 32'h0200);

      // R6: drain received bytes
      for (int j = 0; j < 21; j++) begin
         rd(4'd2, v);  check("R6 rx byte order", v, {24'd0, rxval(j)});
      end
      rd(4'd10, v); check("R6 rx empty after pops", v, 32'd0);

      // R7/R8: shutdown in the middle of a read
      wr(4'd3, 32'h0);
      repeat (3) @(negedge clk);
      rd(4'd4, v);  check("R7 idle shutdown", v, 32'h0);
      push_cmd(1'b1, 8'h00);
      push_cmd(1'b0, 8'h77);
      push_cmd(1'b0, 8'h78);
      wr(4'd3, 32'h1);
      wr(4'd3, 32'h0);
      rd(4'd4, v);  check("R7 enstat held during transfer", v, 32'h1);
      rd(4'd4, v);  check("R7 enstat held to the end", v, 32'h1);
      repeat (20) @(negedge clk);
      check("R7 only the in-flight entry ran", 32'(seen), 32'd65);
      rd(4'd4, v);  check("R7 enstat cleared", v, 32'h0);
      rd(4'd9, v);  check("R8 tx flushed", v, 32'd0);
      rd(4'd10, v); check("R8 rx flushed", v, 32'd0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule